// File: doc/BRIEF.md
# I2C Slave Controller with Clock Stretching

This block is a 7-bit-address I2C slave for a larger chip. It oversamples the open-drain SCL and SDA lines with the system clock and finds START and STOP conditions and clock edges. It shifts in the address and data bytes and acknowledges them by pulling SDA low. It exchanges bytes with a local host through one 8-bit buffer and a few strobes.

On writes from the bus master, the buffer-full and overflow flags decide whether a received byte is stored and whether it is acknowledged. On reads, the slave holds SCL low after each acknowledged byte. It keeps SCL low until the host has written the next byte into the buffer and pulsed the release strobe. An interrupt flag rises once per byte on the falling edge of the ninth clock.

Top module: `i2c_slave_stretch`

## Requirements
- R1: After reset the buffer is 0x00, buf_full_o, ovf_o and irq_o are 0, and both scl_oe_o and sda_oe_o are 0.
- R2: After a START the slave shifts in 8 bits MSB first, sampled on SCL rising edges. Bits 7..1 are the address and bit 0 is R/W (1 = read). When the address equals own_addr_i, the slave drives SDA low during the ninth clock. The address byte is never copied into the buffer.
- R3: irq_o goes to 1 on the falling edge of the ninth SCL pulse of every byte handled by an addressed slave, address bytes included. It stays at 1 until irq_clr_i is pulsed.
- R4: A data byte that completes while buf_full_o = 0 and ovf_o = 0 is copied to the buffer. buf_full_o goes to 1 and the byte is ACKed.
- R5: A data byte that completes while buf_full_o = 1 is not copied and is NACKed (SDA stays high). ovf_o goes to 1, and irq_o still rises.
- R6: buf_rdata_o always shows the buffer. A one-cycle buf_rd_i pulse clears buf_full_o and leaves the buffer unchanged.
- R7: A data byte that completes while buf_full_o = 0 and ovf_o = 1 is copied to the buffer and sets buf_full_o, but is NACKed. ovf_o clears only on ovf_clr_i.
- R8: On an address mismatch the slave does not ACK and irq_o stays unchanged. The slave ignores all following bytes until the next START.
- R9: A START at any point, including in the middle of a byte, restarts address reception. A STOP returns the slave to idle with SDA and SCL released.
- R10: After a matched address with R/W = 1, the slave holds SCL low (scl_oe_o = 1) from the ninth falling edge onward.
- R11: While SCL is held, rel_set_i has no effect unless buf_wr_i has been pulsed since the hold began. After such a write, rel_set_i releases SCL.
- R12: buf_wr_i writes the buffer and loads the transmit shifter. After release, the byte goes out MSB first, and each bit is changed only while SCL is low.
- R13: When the master ACKs a transmitted byte (SDA low at the ninth rising edge), irq_o rises and SCL is held low again.
- R14: When the master NACKs, irq_o rises and both lines are released. The slave then ignores the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| own_addr_i | input | 7 | Own slave address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| buf_rd_i | input | 1 | Host read strobe, clears buffer-full |
| buf_wr_i | input | 1 | Host write strobe |
| buf_wdata_i | input | 8 | Host write data |
| buf_rdata_o | output | 8 | Buffer contents |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| rel_set_i | input | 1 | Clock-release strobe |
| buf_full_o | output | 1 | Buffer-full flag |
| ovf_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Per-byte interrupt flag |

## Verification
The bench sends write streams in three buffer states: drained between bytes, left full, and drained while the overflow flag is still set. These three cases separate the ACK path, the discard path and the late-overflow path (copied but NACKed). A mismatched address followed by data shows that the slave ignores the rest of the transfer. A START in the middle of a byte shows that address reception restarts. Read transfers test a release strobe sent before any buffer write, a master ACK that must cause a new hold, and a master NACK that must leave the slave silent until the next START.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_IGNORE,
    ST_TX_WAIT,
    ST_TX,
    ST_TX_ACK
  } slv_state_e;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edges while SCL is stable high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_slv_engine.sv
module i2c_slv_engine
  import i2c_slv_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              bf_i,
  input  logic              ovf_i,
  input  logic              wr_buf_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              set_rel_i,
  output logic              sda_oe_o,
  output logic              scl_oe_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_push_o,
  output logic              ovf_set_o,
  output logic              irq_set_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_TXL  = CNT_W'(DATA_W - 1);

  slv_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rx_q, rx_d, tx_q, tx_d;
  logic addr_q, addr_d, rw_q, rw_d, ack_q, ack_d, nack_q, nack_d, ld_q, ld_d;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    rx_d      = rx_q;
    tx_d      = tx_q;
    addr_d    = addr_q;
    rw_d      = rw_q;
    ack_d     = ack_q;
    nack_d    = nack_q;
    ld_d      = ld_q;
    rx_push_o = 1'b0;
    ovf_set_o = 1'b0;
    irq_set_o = 1'b0;
    if (start_i) begin
      st_d   = ST_RX;
      cnt_d  = '0;
      addr_d = 1'b1;
      ack_d  = 1'b0;
    end else if (stop_i) begin
      st_d  = ST_IDLE;
      ack_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise_i && cnt_q < CNT_FULL) begin
            rx_d  = {rx_q[DATA_W-2:0], sda_s_i};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == CNT_FULL) begin
            if (addr_q) begin
              if (rx_q[DATA_W-1 -: ADDR_W] == own_addr_i) begin
                ack_d = 1'b1;
                rw_d  = rx_q[0];
                st_d  = ST_RX_ACK;
              end else begin
                st_d = ST_IGNORE;
              end
            end else begin
              // acceptance decided by buffer and overflow state
              ack_d     = ~bf_i & ~ovf_i;
              ovf_set_o = bf_i;
              rx_push_o = ~bf_i;
              st_d      = ST_RX_ACK;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall_i) begin
            irq_set_o = 1'b1;
            ack_d     = 1'b0;
            cnt_d     = '0;
            if (addr_q && rw_q) begin
              st_d = ST_TX_WAIT;
              ld_d = 1'b0;
            end else begin
              st_d = ST_RX;
            end
            addr_d = 1'b0;
          end
        end
        ST_TX_WAIT: begin
          if (set_rel_i && ld_q) begin
            st_d  = ST_TX;
            cnt_d = '0;
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            tx_d  = {tx_q[DATA_W-2:0], 1'b0};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_TXL) st_d = ST_TX_ACK;
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) nack_d = sda_s_i;
          if (scl_fall_i) begin
            irq_set_o = 1'b1;
            ld_d      = 1'b0;
            st_d      = nack_q ? ST_IDLE : ST_TX_WAIT;
          end
        end
        default: ;
      endcase
    end
    if (wr_buf_i) begin
      tx_d = wr_data_i;
      ld_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '1;
      addr_q <= 1'b0;
      rw_q   <= 1'b0;
      ack_q  <= 1'b0;
      nack_q <= 1'b1;
      ld_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      addr_q <= addr_d;
      rw_q   <= rw_d;
      ack_q  <= ack_d;
      nack_q <= nack_d;
      ld_q   <= ld_d;
    end
  end

  assign rx_byte_o = rx_q;
  assign scl_oe_o  = (st_q == ST_TX_WAIT);
  assign sda_oe_o  = (st_q == ST_RX_ACK && ack_q) ||
                     (st_q == ST_TX && ~tx_q[DATA_W-1]) ||
                     (st_q == ST_TX_WAIT && ld_q && ~tx_q[DATA_W-1]);

  AST_SDA_WHILE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s_i); // R12
  AST_HOLD_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> !scl_s_i); // R10
  AST_NACK_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RX && scl_fall_i && cnt_q == CNT_FULL && !addr_q && bf_i && !start_i && !stop_i)
    |=> !sda_oe_o); // R5
  AST_REL_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TX_WAIT && !ld_q && !wr_buf_i && !start_i && !stop_i) |=> scl_oe_o); // R11
endmodule

// File: rtl/i2c_slave_stretch.sv
module i2c_slave_stretch #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              buf_rd_i,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  output logic [DATA_W-1:0] buf_rdata_o,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  input  logic              rel_set_i,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              irq_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic [DATA_W-1:0] rx_byte, buf_q;
  logic rx_push, ovf_set, irq_set, bf_q, ovf_q, irq_q;

  i2c_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_slv_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk_i, .rst_ni, .own_addr_i,
    .scl_s_i(scl_s), .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .bf_i(bf_q), .ovf_i(ovf_q),
    .wr_buf_i(buf_wr_i), .wr_data_i(buf_wdata_i), .set_rel_i(rel_set_i),
    .sda_oe_o, .scl_oe_o, .rx_byte_o(rx_byte), .rx_push_o(rx_push),
    .ovf_set_o(ovf_set), .irq_set_o(irq_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      bf_q  <= 1'b0;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (rx_push)       buf_q <= rx_byte;
      else if (buf_wr_i) buf_q <= buf_wdata_i;
      if (rx_push)       bf_q <= 1'b1;
      else if (buf_rd_i) bf_q <= 1'b0;
      if (ovf_set)        ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
      if (irq_set)        irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign buf_rdata_o = buf_q;
  assign buf_full_o  = bf_q;
  assign ovf_o       = ovf_q;
  assign irq_o       = irq_q;

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q); // R3
  AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bf_q && !buf_rd_i) |=> bf_q); // R6
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q); // R7
  AST_NO_COPY_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bf_q && !buf_wr_i) |=> (buf_q == $past(buf_q))); // R5
endmodule

// File: tb/tb_i2c_slave_stretch.sv
module tb_i2c_slave_stretch;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, scl_bus, sda_bus;
  logic buf_rd = 0, buf_wr = 0, irq_clr = 0, ovf_clr = 0, rel_set = 0;
  logic [7:0] wdata = 0, rdata;
  logic bf, ovf, irq;
  int tests = 0, fails = 0;
  logic cmp_en = 1'b0;
  logic [7:0] exp_buf = 0;
  logic exp_bf = 0, exp_ovf = 0, exp_irq = 0;

  always #2 clk = ~clk;
  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_slave_stretch dut (
    .clk_i(clk), .rst_ni(rst_n), .own_addr_i(OWN), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .buf_rd_i(buf_rd), .buf_wr_i(buf_wr),
    .buf_wdata_i(wdata), .buf_rdata_o(rdata), .irq_clr_i(irq_clr), .ovf_clr_i(ovf_clr),
    .rel_set_i(rel_set), .buf_full_o(bf), .ovf_o(ovf), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // cycle-by-cycle comparison against the behavioural model
  always @(posedge clk) begin
    #1;
    if (cmp_en && rst_n) begin
      check("R6 model buffer", rdata, exp_buf);
      check("R4 model buf_full", bf, exp_bf);
      check("R7 model overflow", ovf, exp_ovf);
      check("R3 model irq", irq, exp_irq);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic mbit(input logic b, output logic r);
    sda_m = b; wait_q();
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_bus);
    wait_q();
    r = sda_bus;
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q(); sda_m = 1'b1; wait_q();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) mbit(b[i], r);
    mbit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic ack_m);
    logic r;
    cmp_en = 1'b0;
    for (int i = 7; i >= 0; i--) begin mbit(1'b1, r); d[i] = r; end
    mbit(~ack_m, r);
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw);
    logic ack;
    cmp_en = 1'b0;
    wbyte({a, rw}, ack);
    if (a == OWN) begin
      check("R2 address ack", ack, 1);
      exp_irq = 1'b1;
    end else begin
      check("R8 mismatch nack", ack, 0);
    end
    cmp_en = 1'b1;
  endtask

  task automatic send_data(input logic [7:0] b, input logic sel);
    logic ack, e_ack;
    string tag;
    cmp_en = 1'b0;
    wbyte(b, ack);
    if (!sel) begin
      e_ack = 1'b0; tag = "R8 ignored data nack";
    end else if (exp_bf) begin
      e_ack = 1'b0; tag = "R5 full nack"; exp_ovf = 1'b1; exp_irq = 1'b1;
    end else begin
      e_ack = ~exp_ovf; tag = exp_ovf ? "R7 late overflow nack" : "R4 accept ack";
      exp_buf = b; exp_bf = 1'b1; exp_irq = 1'b1;
    end
    check(tag, ack, e_ack);
    cmp_en = 1'b1;
  endtask

  task automatic host_read(output logic [7:0] d);
    @(negedge clk); d = rdata; buf_rd = 1'b1; exp_bf = 1'b0;
    @(negedge clk); buf_rd = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); wdata = d; buf_wr = 1'b1; exp_buf = d;
    @(negedge clk); buf_wr = 1'b0;
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr = 1'b1; exp_irq = 1'b0;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic clr_ovf();
    @(negedge clk); ovf_clr = 1'b1; exp_ovf = 1'b0;
    @(negedge clk); ovf_clr = 1'b0;
  endtask

  task automatic release_scl();
    @(negedge clk); rel_set = 1'b1;
    @(negedge clk); rel_set = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    logic r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 buf_full", bf, 0);
    check("R1 overflow", ovf, 0);
    check("R1 irq", irq, 0);
    check("R1 buffer", rdata, 0);
    check("R1 scl released", scl_oe, 0);
    check("R1 sda released", sda_oe, 0);
    cmp_en = 1'b1;

    // write transfer: accept, overflow, late overflow
    bus_start();
    send_addr(OWN, 1'b0);
    check("R3 irq on address byte", irq, 1);
    check("R2 address not buffered", bf, 0);
    clr_irq();
    send_data(8'hA5, 1'b1);
    check("R4 buffer holds byte", rdata, 8'hA5);
    clr_irq();
    send_data(8'h5A, 1'b1);
    check("R5 overflow set", ovf, 1);
    check("R5 byte discarded", rdata, 8'hA5);
    check("R5 irq still raised", irq, 1);
    clr_irq();
    host_read(d);
    check("R6 host read data", d, 8'hA5);
    @(negedge clk);
    check("R6 buf_full cleared", bf, 0);
    send_data(8'hC3, 1'b1);
    check("R7 byte copied under overflow", rdata, 8'hC3);
    check("R7 overflow kept", ovf, 1);
    clr_irq();
    clr_ovf();
    host_read(d);
    send_data(8'h11, 1'b1);
    clr_irq();
    bus_stop();
    wait_q();
    check("R9 stop releases sda", sda_oe, 0);
    check("R9 stop releases scl", scl_oe, 0);
    host_read(d);

    // address mismatch
    bus_start();
    send_addr(7'h15, 1'b0);
    send_data(8'h77, 1'b0);
    check("R8 no irq on mismatch", irq, 0);
    check("R8 buffer untouched", bf, 0);
    bus_stop();

    // repeated START in the middle of a byte
    bus_start();
    send_addr(OWN, 1'b0);
    clr_irq();
    cmp_en = 1'b0;
    mbit(1'b1, r); mbit(1'b0, r); mbit(1'b1, r);
    bus_start();
    cmp_en = 1'b1;
    send_addr(OWN, 1'b0);
    check("R9 restart address accepted", irq, 1);
    clr_irq();
    bus_stop();

    // read transfer with stretching
    bus_start();
    send_addr(OWN, 1'b1);
    check("R10 scl held after read address", scl_oe, 1);
    release_scl();
    repeat (20) @(negedge clk);
    check("R11 release ignored before write", scl_oe, 1);
    host_write(8'h3C);
    release_scl();
    repeat (3) @(negedge clk);
    check("R11 release after write", scl_oe, 0);
    clr_irq();
    rbyte(d, 1'b1);
    exp_irq = 1'b1;
    cmp_en = 1'b1;
    check("R12 transmitted byte", d, 8'h3C);
    check("R13 hold again after master ack", scl_oe, 1);
    check("R13 irq after transmitted byte", irq, 1);
    clr_irq();
    host_write(8'h81);
    release_scl();
    repeat (3) @(negedge clk);
    rbyte(d, 1'b0);
    exp_irq = 1'b1;
    cmp_en = 1'b1;
    check("R12 second transmitted byte", d, 8'h81);
    check("R14 scl released after nack", scl_oe, 0);
    check("R14 sda released after nack", sda_oe, 0);
    check("R14 irq after nack byte", irq, 1);
    clr_irq();
    rbyte(d, 1'b0);
    cmp_en = 1'b1;
    check("R14 slave silent after nack", d, 8'hFF);
    check("R14 no irq while ignoring", irq, 0);
    bus_stop();
    wait_q();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule